// File: doc/BRIEF.md
# DMA Request Handshake Controller for a Packet FIFO Port

This block paces an external DMA engine against one packet FIFO port. It raises a request line when the port can move a data unit, takes each acknowledge strobe from the engine as one moved unit, counts down the number of units assigned to the transfer, and keeps a small occupancy count for the port. Two pacing modes exist. In single-unit mode the request drops after every acknowledge and returns only once the strobe is gone. In held mode the request stays up for as long as a unit can still move.

A transfer begins with a start pulse that loads the unit budget. It ends when that budget reaches zero, or when the engine marks an acknowledged unit as the last one with its end strobe. An end strobe raises a sticky flag that blocks further requests until the flag is cleared. The acknowledge can come from a dedicated acknowledge pin or from chip-select together with the read or write strobe. All strobe pins are active-low and asynchronous. A zero-length packet arriving on the USB side empties the occupancy count.

Top module: `dma_port_hs`

## Requirements
- R1: With `cfg_burst`=0, `dma_req` is low in the cycle after the selected acknowledge is seen asserted after synchronization. It returns high only after the acknowledge has been seen released.
- R2: With `cfg_burst`=1, `dma_req` stays high across acknowledges while R3's conditions hold.
- R3: `dma_req` is high only if `cfg_en`=1, a transfer is active, `tend_flag`=0, and the port can move a unit. With `cfg_dir_rd`=1 (port to DMA) that means `fifo_level`>0. With `cfg_dir_rd`=0 (DMA to port) it means `fifo_level`<DEPTH.
- R4: `start` loads `units_left` with `xfer_len` and clears `xfer_done`. A length of zero sets `xfer_done` at once. Each accepted unit lowers `units_left` by one. When it reaches zero, the transfer stops and `xfer_done` is set.
- R5: With `cfg_ack_pin`=1, only `dack_n` acknowledges. With `cfg_ack_pin`=0, only `cs_n` low together with `rd_n` low (read direction) or `wr_n` low (write direction) acknowledges. Strobes from the other source move no unit.
- R6: A low `dend_n` counts only when it coincides with an accepted acknowledge edge. It then ends the transfer, sets `xfer_done` and sets `tend_flag`. `tend_flag` stays set until a `tend_clr` pulse and blocks `dma_req` while set.
- R7: `zlp_rx` clears `fifo_level` to 0 on the next edge, taking priority over any count change in that cycle.
- R8: Each strobe pin passes two flops. A unit whose acknowledge goes low before an edge is counted on the third rising edge.
- R9: After reset, `dma_req`, `xfer_done`, `tend_flag`, `units_left` and `fifo_level` are all zero.
- R10: `fifo_level` saturates at 0 and at DEPTH. A USB-side strobe and an accepted unit in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables DMA requests for the port |
| cfg_burst | input | 1 | 1 = held request, 0 = one request per unit |
| cfg_ack_pin | input | 1 | 1 = dedicated acknowledge, 0 = chip-select with read/write |
| cfg_dir_rd | input | 1 | 1 = DMA reads the port, 0 = DMA writes it |
| start | input | 1 | Loads a new transfer budget |
| xfer_len | input | CNT_W | Unit budget for the transfer |
| tend_clr | input | 1 | Clears the end-strobe flag |
| usb_stb | input | 1 | USB side moves one unit (fills in read, drains in write) |
| zlp_rx | input | 1 | Zero-length packet seen on the USB side |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | 1 | Dedicated DMA acknowledge, active low |
| dend_n | input | 1 | Transfer-end strobe, active low |
| dma_req | output | 1 | DMA request |
| xfer_done | output | 1 | Transfer finished |
| tend_flag | output | 1 | Sticky end-strobe flag |
| units_left | output | CNT_W | Units still to move |
| fifo_level | output | LVL_W | Port occupancy |

## Verification
Strobes are driven shortly after a falling edge. Their effect on `units_left` and `fifo_level` is due after the third rising edge. The single-unit drop of `dma_req` is due in the same cycle. Synchronous controls (`start`, `tend_clr`, `zlp_rx`, `usb_stb`) act on the next rising edge. The bench model applies each stimulus at the rising edge where the design sees it and compares every output at the following falling edge. Targeted checks sample at exactly those counted edges, so an extra or a missing register shows up as a mismatch.

// File: rtl/dma_hs_pkg.sv
`timescale 1ns/1ps
package dma_hs_pkg;
  localparam int HS_W    = 5;
  localparam int HS_CS   = 0;
  localparam int HS_RD   = 1;
  localparam int HS_WR   = 2;
  localparam int HS_DACK = 3;
  localparam int HS_DEND = 4;
  typedef logic [HS_W-1:0] hs_vec_t;
endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync
  import dma_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  hs_vec_t pin_n,
  output hs_vec_t pin_on
);
  generate
    for (genvar i = 0; i < HS_W; i++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          stab_q <= 1'b1;
        end else begin
          meta_q <= pin_n[i];
          stab_q <= meta_q;
        end
      end
      assign pin_on[i] = ~stab_q;
    end
  endgenerate
endmodule

// File: rtl/hs_unit_detect.sv
`timescale 1ns/1ps
module hs_unit_detect
  import dma_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  hs_vec_t pin_on,
  input  logic    ack_pin,
  input  logic    dir_rd,
  output logic    ack_now,
  output logic    ack_prev,
  output logic    ack_rise,
  output logic    end_now
);
  logic prev_d;

  always_comb begin
    if (ack_pin) ack_now = pin_on[HS_DACK];
    else         ack_now = pin_on[HS_CS] & (dir_rd ? pin_on[HS_RD] : pin_on[HS_WR]);
    end_now  = pin_on[HS_DEND];
    ack_rise = ack_now & ~ack_prev;
    prev_d   = ack_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b0;
    else        ack_prev <= prev_d;
  end
endmodule

// File: rtl/xfer_budget.sv
`timescale 1ns/1ps
module xfer_budget #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             unit,
  input  logic             end_strobe,
  input  logic             tend_clr,
  output logic [CNT_W-1:0] left_q,
  output logic             act_q,
  output logic             done_q,
  output logic             tend_q
);
  logic [CNT_W-1:0] left_d;
  logic act_d, done_d, tend_d, upd_en, take;

  assign take   = unit & act_q;
  assign upd_en = start | take | tend_clr;

  always_comb begin
    left_d = left_q;
    act_d  = act_q;
    done_d = done_q;
    tend_d = tend_q;
    if (tend_clr) tend_d = 1'b0;
    if (start) begin
      left_d = len;
      act_d  = (len != '0);
      done_d = (len == '0);
    end else if (take) begin
      left_d = left_q - 1'b1;
      if (end_strobe || left_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
      if (end_strobe) tend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      tend_q <= 1'b0;
    end else if (upd_en) begin
      left_q <= left_d;
      act_q  <= act_d;
      done_q <= done_d;
      tend_q <= tend_d;
    end
  end

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start && !end_strobe && left_q > 1) |=> (left_q == $past(left_q) - 1'b1) && act_q);
  p_budget_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start && left_q == 1) |=> (done_q && !act_q));
  p_tend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tend_q && !tend_clr) |=> tend_q);
  p_tend_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend_q) |-> $past(take && end_strobe));
endmodule

// File: rtl/port_level.sv
`timescale 1ns/1ps
module port_level #(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic             usb_stb,
  input  logic             unit,
  input  logic             zlp,
  output logic [LVL_W-1:0] lvl_q
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  logic inc, dec, upd_en;
  logic [LVL_W-1:0] lvl_d;

  assign inc    = dir_rd ? usb_stb : unit;
  assign dec    = dir_rd ? unit : usb_stb;
  assign upd_en = zlp | (inc ^ dec);

  always_comb begin
    lvl_d = lvl_q;
    if (zlp)                           lvl_d = '0;
    else if (inc && !dec && lvl_q < FULL) lvl_d = lvl_q + 1'b1;
    else if (dec && !inc && lvl_q != '0)  lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (upd_en) lvl_q <= lvl_d;
  end

  p_zlp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zlp |=> (lvl_q == '0));
  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= FULL);
  p_level_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!zlp && inc && dec) |=> $stable(lvl_q));
endmodule

// File: rtl/dma_port_hs.sv
`timescale 1ns/1ps
module dma_port_hs
  import dma_hs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_burst,
  input  logic             cfg_ack_pin,
  input  logic             cfg_dir_rd,
  input  logic             start,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             tend_clr,
  input  logic             usb_stb,
  input  logic             zlp_rx,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             dack_n,
  input  logic             dend_n,
  output logic             dma_req,
  output logic             xfer_done,
  output logic             tend_flag,
  output logic [CNT_W-1:0] units_left,
  output logic [LVL_W-1:0] fifo_level
);
  logic rst_m_q, rst_s_q, srst_n;
  hs_vec_t pins_n, pins_on;
  logic ack_now, ack_prev, ack_rise, end_now, act, room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  assign srst_n = rst_s_q;

  assign pins_n = {dend_n, dack_n, wr_n, rd_n, cs_n};

  hs_sync u_sync (
    .clk(clk), .rst_n(srst_n), .pin_n(pins_n), .pin_on(pins_on)
  );

  hs_unit_detect u_det (
    .clk(clk), .rst_n(srst_n), .pin_on(pins_on), .ack_pin(cfg_ack_pin),
    .dir_rd(cfg_dir_rd), .ack_now(ack_now), .ack_prev(ack_prev),
    .ack_rise(ack_rise), .end_now(end_now)
  );

  xfer_budget #(.CNT_W(CNT_W)) u_bud (
    .clk(clk), .rst_n(srst_n), .start(start), .len(xfer_len),
    .unit(ack_rise), .end_strobe(end_now), .tend_clr(tend_clr),
    .left_q(units_left), .act_q(act), .done_q(xfer_done), .tend_q(tend_flag)
  );

  port_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst_n(srst_n), .dir_rd(cfg_dir_rd), .usb_stb(usb_stb),
    .unit(ack_rise & act), .zlp(zlp_rx), .lvl_q(fifo_level)
  );

  assign room    = cfg_dir_rd ? (fifo_level != '0) : (fifo_level < LVL_W'(DEPTH));
  assign dma_req = cfg_en & act & ~tend_flag & room & (cfg_burst | ~ack_prev);

  p_req_gate_r3: assert property (@(posedge clk) disable iff (!srst_n)
    dma_req |-> (cfg_en && !tend_flag && !xfer_done));
  p_single_drop_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (!cfg_burst && ack_now) |=> (!dma_req || cfg_burst));
  p_held_req_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_burst && dma_req && !ack_rise && !start && !tend_clr && !zlp_rx && !usb_stb
     && $stable(cfg_en) && $stable(cfg_burst) && $stable(cfg_dir_rd)) |=> dma_req);
endmodule

// File: tb/dma_port_hs_tb.sv
`timescale 1ns/1ps
module dma_port_hs_tb;
  localparam int CNT_W = 8;
  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_en, cfg_burst, cfg_ack_pin, cfg_dir_rd, start, tend_clr, usb_stb, zlp_rx;
  logic cs_n, rd_n, wr_n, dack_n, dend_n;
  logic [CNT_W-1:0] xfer_len, units_left;
  logic [LVL_W-1:0] fifo_level;
  logic dma_req, xfer_done, tend_flag;

  dma_port_hs #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_burst(cfg_burst),
    .cfg_ack_pin(cfg_ack_pin), .cfg_dir_rd(cfg_dir_rd), .start(start),
    .xfer_len(xfer_len), .tend_clr(tend_clr), .usb_stb(usb_stb), .zlp_rx(zlp_rx),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n), .dend_n(dend_n),
    .dma_req(dma_req), .xfer_done(xfer_done), .tend_flag(tend_flag),
    .units_left(units_left), .fifo_level(fifo_level)
  );

  int checks = 0, bad = 0;
  bit cmp_en = 0, finished = 0;

  // reference model state (asserted-high pin history)
  logic [4:0] m_s1, m_s2;
  bit m_ackd, m_act, m_done, m_tend;
  int m_lvl, m_rem;

  function automatic bit ack_of(logic [4:0] a);
    if (cfg_ack_pin) return a[3];
    return a[0] && (cfg_dir_rd ? a[1] : a[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_ackd = 0; m_lvl = 0; m_rem = 0;
      m_act = 0; m_done = 0; m_tend = 0;
    end else begin
      bit a_now, unit, dok;
      int step;
      a_now = ack_of(m_s2);
      unit  = a_now && !m_ackd && m_act;
      dok   = unit && m_s2[4];
      step = 0;
      if (usb_stb) step += cfg_dir_rd ? 1 : -1;
      if (unit)    step += cfg_dir_rd ? -1 : 1;
      if (zlp_rx) m_lvl = 0;
      else if (step > 0 && m_lvl < DEPTH) m_lvl++;
      else if (step < 0 && m_lvl > 0) m_lvl--;
      if (tend_clr) m_tend = 0;
      if (start) begin
        m_rem = xfer_len; m_act = (xfer_len != 0); m_done = (xfer_len == 0);
      end else if (unit) begin
        m_rem--;
        if (dok || m_rem == 0) begin m_act = 0; m_done = 1; end
        if (dok) m_tend = 1;
      end
      m_ackd = a_now;
      m_s2 = m_s1;
      m_s1 = ~{dend_n, dack_n, wr_n, rd_n, cs_n};
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_req();
    bit room;
    room = cfg_dir_rd ? (m_lvl > 0) : (m_lvl < DEPTH);
    return cfg_en && m_act && !m_tend && room && (cfg_burst || !m_ackd);
  endfunction

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(cfg_burst ? "R2 req" : "R1 req", dma_req, exp_req());
      chk("R4 done", xfer_done, m_done);
      chk("R6 tend", tend_flag, m_tend);
      chk("R4 left", units_left, m_rem);
      chk("R7 level", fifo_level, m_lvl);
    end
  end

  task automatic drive_ack(bit on, bit fin);
    if (cfg_ack_pin) dack_n = !on;
    else begin
      cs_n = !on;
      if (cfg_dir_rd) rd_n = !on; else wr_n = !on;
    end
    dend_n = !(on && fin);
  endtask

  task automatic wait_req();
    for (int t = 0; t < 40 && !dma_req; t++) @(negedge clk);
  endtask

  task automatic do_unit(bit fin, bit probe);
    int r0;
    wait_req();
    @(negedge clk); r0 = units_left;
    #1 drive_ack(1, fin);
    if (probe) begin
      @(negedge clk); chk("R8 first edge", units_left, r0);
      @(negedge clk); chk("R8 second edge", units_left, r0);
      @(negedge clk); chk("R8 third edge", units_left, r0 - 1);
      if (cfg_burst) chk("R2 held", dma_req, 1);
      else           chk("R1 dropped", dma_req, 0);
      @(negedge clk);
    end else repeat (4) @(negedge clk);
    #1 drive_ack(0, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start(int len);
    @(negedge clk); #1 start = 1; xfer_len = CNT_W'(len);
    @(negedge clk); #1 start = 0;
  endtask

  task automatic pulse_usb(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 usb_stb = 1;
      @(negedge clk); #1 usb_stb = 0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 0; cfg_en = 0; cfg_burst = 0; cfg_ack_pin = 0; cfg_dir_rd = 1;
    start = 0; xfer_len = '0; tend_clr = 0; usb_stb = 0; zlp_rx = 0;
    cs_n = 1; rd_n = 1; wr_n = 1; dack_n = 1; dend_n = 1;
    idle(3); #1 rst_n = 1;
    idle(4);
    // R9 reset state
    chk("R9 req", dma_req, 0); chk("R9 done", xfer_done, 0); chk("R9 tend", tend_flag, 0);
    chk("R9 left", units_left, 0); chk("R9 level", fifo_level, 0);
    cmp_en = 1;

    // single-unit pacing, chip-select strobes, read direction (R1, R8, R3, R4)
    #1 cfg_en = 1;
    pulse_usb(3);
    pulse_start(4);
    idle(2);
    chk("R3 req with data", dma_req, 1);
    do_unit(0, 1);
    do_unit(0, 0);
    do_unit(0, 0);
    chk("R3 no data no req", dma_req, 0);
    pulse_usb(1);
    do_unit(0, 0);
    chk("R4 budget done", xfer_done, 1);
    chk("R4 req off", dma_req, 0);

    // held pacing, dedicated acknowledge, write direction (R2, R4)
    #1 cfg_dir_rd = 0; cfg_burst = 1; cfg_ack_pin = 1;
    pulse_start(3);
    do_unit(0, 1);
    do_unit(0, 0);
    do_unit(0, 0);
    chk("R4 done write", xfer_done, 1);
    chk("R4 level filled", fifo_level, 3);
    pulse_usb(1);

    // wrong acknowledge source ignored (R5)
    pulse_start(2);
    @(negedge clk); #1 cs_n = 0; wr_n = 0;
    idle(6); #1 cs_n = 1; wr_n = 1;
    idle(4);
    chk("R5 other source ignored", units_left, 2);
    do_unit(0, 0);
    chk("R5 dack counted", units_left, 1);

    // end strobe (R6)
    pulse_start(5);
    @(negedge clk); #1 dend_n = 0;
    idle(5); #1 dend_n = 1;
    idle(4);
    chk("R6 lone end ignored", tend_flag, 0);
    chk("R6 lone end left", units_left, 5);
    do_unit(0, 0);
    do_unit(1, 0);
    chk("R6 flag set", tend_flag, 1);
    chk("R6 ends transfer", xfer_done, 1);
    chk("R6 left", units_left, 3);
    pulse_start(2);
    idle(3);
    chk("R6 flag blocks req", dma_req, 0);
    @(negedge clk); #1 tend_clr = 1;
    @(negedge clk); #1 tend_clr = 0;
    chk("R6 cleared", tend_flag, 0);
    chk("R6 req resumes", dma_req, 1);
    do_unit(0, 0);
    do_unit(0, 0);

    // saturation and zero-length packet (R10, R7), single-unit pacing read direction
    #1 cfg_dir_rd = 1; cfg_burst = 0; cfg_ack_pin = 0;
    pulse_usb(4);
    chk("R10 saturate", fifo_level, DEPTH);
    @(negedge clk); #1 zlp_rx = 1;
    @(negedge clk); #1 zlp_rx = 0;
    chk("R7 cleared", fifo_level, 0);
    pulse_usb(2);
    @(negedge clk); #1 zlp_rx = 1; usb_stb = 1;
    @(negedge clk); #1 zlp_rx = 0; usb_stb = 0;
    chk("R7 priority", fifo_level, 0);

    // enable gate and zero budget (R3, R4)
    #1 cfg_en = 0;
    pulse_usb(2);
    pulse_start(3);
    idle(3);
    chk("R3 disabled", dma_req, 0);
    #1 cfg_en = 1;
    @(negedge clk);
    chk("R3 enabled", dma_req, 1);
    do_unit(0, 0);
    pulse_start(0);
    idle(1);
    chk("R4 zero budget done", xfer_done, 1);
    chk("R4 zero budget req", dma_req, 0);

    idle(3);
    summary();
  end
endmodule